// File: doc/BRIEF.md
# UART Dual Character FIFO

This block sits between a register interface and a UART serial engine. It holds outgoing characters until the engine takes them, and incoming characters until software reads them. Software writes characters to a data register to queue them for transmission. It reads the same register to pop received characters. A control register turns each FIFO on, flushes either one, and enables the interrupts. One 16-bit count register reports both fill levels: the transmit level in bits 7:0 and the receive level in bits 15:8.

The transmit side keeps a refill request flag. The hardware sets this flag whenever the transmit FIFO is enabled and empty. The flag stays set until software writes it to 0, which software does after loading new characters. The receive side raises an interrupt in either of two cases: the fill level reaches a programmable trigger, or characters have waited through several character times without a new start bit. The serial engine supplies a pulse each time a start bit begins and a pulse once per character time, which the idle timer uses.

Top module: `uart_dual_fifo`

## Requirements
- R1: After reset, both fill levels read 0, the control register reads 0x0000, tx_valid is low, and irq_tx and irq_rx are low.
- R2: With the transmit FIFO enabled (control bit 0), each write to the data register (address 0) queues wdata[7:0]. tx_char shows the oldest queued character while tx_valid is high, and each tx_take pulse removes that character. The fill level in count bits 7:0 changes in the cycle after each push or pop.
- R3: The transmit FIFO holds DEPTH (128) characters. A data write while it is full is dropped, and the level stays at DEPTH.
- R4: With the receive FIFO enabled (control bit 1), each rx_strobe stores rx_char. A read of the data register returns the oldest stored character and removes it. The receive fill level is in count bits 15:8.
- R5: An rx_strobe that arrives while the receive FIFO is full discards the character and sets the overrun flag (control bit 12). A control write with bit 12 at 0 clears the flag, and so does a receive flush.
- R6: A FIFO whose enable bit is 0 ignores pushes: data writes for transmit, rx_strobe for receive. While the transmit FIFO is disabled, tx_valid stays low.
- R7: Writing 1 to control bit 2 empties the transmit FIFO, and writing 1 to bit 3 empties the receive FIFO. Each flush acts in the following cycle and leaves the other FIFO untouched. Both bits read back as 0.
- R8: The refill request flag (control bit 10) is set in every cycle in which the transmit FIFO is enabled and empty. Once set, it stays set until a control write with bit 10 at 0. Writing bit 10 as 1 never sets it.
- R9: irq_tx is high exactly when the transmit-empty interrupt enable (control bit 9) and the refill request flag are both set.
- R10: A write to the count register (address 2) loads wdata[15:8] as the receive trigger. When the trigger is nonzero and the receive fill level is at or above it, irq_rx is high. A trigger of 0 disables this source.
- R11: When the receive FIFO is not empty and IDLE_CHARS (4) char_tick pulses arrive with no rx_start or rx_strobe in between, the block enters the idle state. In that state irq_rx is high if the idle interrupt enable (control bit 11) is set. An rx_start pulse leaves the idle state in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive FIFO at address 0) |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 count |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational from bus_addr |
| tx_valid | output | 1 | A transmit character is available |
| tx_char | output | 8 | Oldest transmit character |
| tx_take | input | 1 | Engine takes the transmit character |
| rx_strobe | input | 1 | Engine delivers a received character |
| rx_char | input | 8 | Received character |
| rx_start | input | 1 | Engine detected a start bit |
| char_tick | input | 1 | One pulse per character time |
| irq_tx | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive threshold or idle interrupt |

## Verification
The assertions assume that the bus and engine strobes are single-cycle pulses. They also assume that a read and a write of the bus never fall in the same cycle. Under those conditions, the properties on fill-level steps and flush behaviour are meaningful. Every bench task raises exactly one strobe for one clock and lowers it before the next task starts. tx_take is only pulsed after tx_valid has been seen high, so the assumed input discipline holds throughout the run.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int CHAR_W = 8;

    localparam logic [1:0] ADDR_DATA  = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_COUNT = 2'd2;

    // control register bit positions (software depends on these)
    localparam int CB_TX_EN    = 0;
    localparam int CB_RX_EN    = 1;
    localparam int CB_TX_FLUSH = 2;
    localparam int CB_RX_FLUSH = 3;
    localparam int CB_TX_IE    = 9;
    localparam int CB_DRQ      = 10;
    localparam int CB_IDLE_IE  = 11;
    localparam int CB_OVR      = 12;

    // decoded control write
    typedef struct packed {
        logic tx_en;
        logic rx_en;
        logic tx_flush;
        logic rx_flush;
        logic tx_ie;
        logic drq_keep;
        logic idle_ie;
        logic ovr_keep;
    } ctrl_cmd_t;

    // stored control state
    typedef struct packed {
        logic tx_en;
        logic rx_en;
        logic tx_ie;
        logic drq;
        logic idle_ie;
        logic ovr;
    } ctrl_state_t;

    function automatic logic [15:0] ctrl_word(ctrl_state_t s);
        logic [15:0] w;
        w              = '0;
        w[CB_TX_EN]    = s.tx_en;
        w[CB_RX_EN]    = s.rx_en;
        w[CB_TX_IE]    = s.tx_ie;
        w[CB_DRQ]      = s.drq;
        w[CB_IDLE_IE]  = s.idle_ie;
        w[CB_OVR]      = s.ovr;
        return w;
    endfunction

    function automatic logic [15:0] count_word(logic [7:0] tx_lvl, logic [7:0] rx_lvl);
        return {rx_lvl, tx_lvl};
    endfunction

endpackage

// File: rtl/ufq_fifo.sv
module ufq_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          push,
    input  logic [W-1:0]                  din,
    input  logic                          pop,
    output logic [W-1:0]                  dout,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          full,
    output logic                          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rptr];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/ufq_ctrl.sv
module ufq_ctrl
    import uart_fifo_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         ctrl_wr,
    input  ctrl_cmd_t    cmd,
    input  logic         trig_wr,
    input  logic [7:0]   trig_val,
    input  logic         tx_empty,
    input  logic         ovr_evt,
    output ctrl_state_t  st,
    output logic [7:0]   trig
);
    ctrl_state_t st_q;
    logic        drq_clr, ovr_clr, rx_flush;

    assign drq_clr  = ctrl_wr && !cmd.drq_keep;
    assign rx_flush = ctrl_wr && cmd.rx_flush;
    assign ovr_clr  = (ctrl_wr && !cmd.ovr_keep) || rx_flush;
    assign st       = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            trig <= '0;
        end else begin
            if (ctrl_wr) begin
                st_q.tx_en   <= cmd.tx_en;
                st_q.rx_en   <= cmd.rx_en;
                st_q.tx_ie   <= cmd.tx_ie;
                st_q.idle_ie <= cmd.idle_ie;
            end
            // hardware set has priority over software clear
            if (st_q.tx_en && tx_empty) begin
                st_q.drq <= 1'b1;
            end else if (drq_clr) begin
                st_q.drq <= 1'b0;
            end
            if (ovr_evt && !rx_flush) begin
                st_q.ovr <= 1'b1;
            end else if (ovr_clr) begin
                st_q.ovr <= 1'b0;
            end
            if (trig_wr) begin
                trig <= trig_val;
            end
        end
    end
endmodule

// File: rtl/ufq_idle.sv
module ufq_idle #(
    parameter int IDLE_CHARS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic rx_empty,
    input  logic char_tick,
    output logic idle
);
    localparam int ICW = $clog2(IDLE_CHARS + 1);
    localparam logic [ICW-1:0] LIMIT = ICW'(IDLE_CHARS);

    logic [ICW-1:0] ticks_q;

    assign idle = (ticks_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || restart || rx_empty) begin
            ticks_q <= '0;
        end else if (char_tick && !idle) begin
            ticks_q <= ticks_q + 1'b1;
        end
    end
endmodule

// File: rtl/uart_dual_fifo.sv
module uart_dual_fifo
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH      = 128,
    parameter int IDLE_CHARS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_char,
    input  logic        tx_take,
    input  logic        rx_strobe,
    input  logic [7:0]  rx_char,
    input  logic        rx_start,
    input  logic        char_tick,
    output logic        irq_tx,
    output logic        irq_rx
);
    localparam int CW = $clog2(DEPTH + 1);

    ctrl_cmd_t          cmd;
    ctrl_state_t        st_q;
    logic [7:0]         trig_q;
    logic               ctrl_wr, data_wr, data_rd, trig_wr;
    logic               tx_flush, rx_flush;
    logic               tx_push, tx_pop, rx_push, rx_pop;
    logic [CW-1:0]      tx_cnt, rx_cnt;
    logic               tx_full, tx_empty, rx_full, rx_empty;
    logic [CHAR_W-1:0]  tx_head, rx_head;
    logic               ovr_evt, rx_idle, thresh_hit;

    // register decode
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign data_wr = bus_wr && (bus_addr == ADDR_DATA);
    assign data_rd = bus_rd && (bus_addr == ADDR_DATA);
    assign trig_wr = bus_wr && (bus_addr == ADDR_COUNT);

    always_comb begin
        cmd.tx_en    = bus_wdata[CB_TX_EN];
        cmd.rx_en    = bus_wdata[CB_RX_EN];
        cmd.tx_flush = bus_wdata[CB_TX_FLUSH];
        cmd.rx_flush = bus_wdata[CB_RX_FLUSH];
        cmd.tx_ie    = bus_wdata[CB_TX_IE];
        cmd.drq_keep = bus_wdata[CB_DRQ];
        cmd.idle_ie  = bus_wdata[CB_IDLE_IE];
        cmd.ovr_keep = bus_wdata[CB_OVR];
    end

    assign tx_flush = ctrl_wr && cmd.tx_flush;
    assign rx_flush = ctrl_wr && cmd.rx_flush;
    assign tx_push  = data_wr && st_q.tx_en && !tx_full;
    assign tx_pop   = tx_take && tx_valid;
    assign rx_push  = rx_strobe && st_q.rx_en;
    assign rx_pop   = data_rd;
    assign ovr_evt  = rx_push && rx_full;

    ufq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .cmd      (cmd),
        .trig_wr  (trig_wr),
        .trig_val (bus_wdata[15:8]),
        .tx_empty (tx_empty),
        .ovr_evt  (ovr_evt),
        .st       (st_q),
        .trig     (trig_q)
    );

    ufq_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_flush),
        .push  (tx_push),
        .din   (bus_wdata[CHAR_W-1:0]),
        .pop   (tx_pop),
        .dout  (tx_head),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    ufq_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_flush),
        .push  (rx_push),
        .din   (rx_char),
        .pop   (rx_pop),
        .dout  (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    ufq_idle #(.IDLE_CHARS(IDLE_CHARS)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .restart   (rx_start || rx_strobe || rx_flush),
        .rx_empty  (rx_empty),
        .char_tick (char_tick),
        .idle      (rx_idle)
    );

    assign tx_valid   = st_q.tx_en && !tx_empty;
    assign tx_char    = tx_head;
    assign thresh_hit = (trig_q != '0) && (16'(rx_cnt) >= 16'(trig_q));
    assign irq_tx     = st_q.tx_ie && st_q.drq;
    assign irq_rx     = thresh_hit || (st_q.idle_ie && rx_idle);

    always_comb begin
        case (bus_addr)
            ADDR_DATA:  bus_rdata = rx_empty ? 16'h0000 : {8'h00, rx_head};
            ADDR_CTRL:  bus_rdata = ctrl_word(st_q);
            ADDR_COUNT: bus_rdata = count_word(8'(tx_cnt), 8'(rx_cnt));
            default:    bus_rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/ufq_checker.sv
module ufq_checker #(
    parameter int DEPTH = 128
) (
    input logic                       clk,
    input logic                       rst,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic                       tx_pop,
    input logic                       tx_flush,
    input logic                       rx_flush,
    input logic                       rx_strobe,
    input logic                       rx_en,
    input logic                       rx_full,
    input logic                       ovr,
    input logic                       rx_start,
    input logic                       rx_idle,
    input logic                       tx_en
);
    localparam int CW = $clog2(DEPTH + 1);

    AST_TX_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        tx_cnt <= CW'(DEPTH)); // R3
    AST_RX_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        rx_cnt <= CW'(DEPTH)); // R4
    AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt == CW'(DEPTH) && !tx_pop && !tx_flush) |=> tx_cnt == CW'(DEPTH)); // R3
    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> tx_cnt == '0); // R7
    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> rx_cnt == '0); // R7
    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && rx_en && rx_full && !rx_flush) |=> ovr); // R5
    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (rst)
        rx_start |=> !rx_idle); // R11
    AST_TX_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !tx_flush) |=> tx_cnt == $past(tx_cnt)); // R6
    AST_RX_STEP: assert property (@(posedge clk) disable iff (rst)
        !rx_flush |=> ((rx_cnt == $past(rx_cnt)) || (rx_cnt == $past(rx_cnt) + 1'b1)
                       || (rx_cnt + 1'b1 == $past(rx_cnt)))); // R4
endmodule

bind uart_dual_fifo ufq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt),
    .tx_pop    (tx_pop),
    .tx_flush  (tx_flush),
    .rx_flush  (rx_flush),
    .rx_strobe (rx_strobe),
    .rx_en     (st_q.rx_en),
    .rx_full   (rx_full),
    .ovr       (st_q.ovr),
    .rx_start  (rx_start),
    .rx_idle   (rx_idle),
    .tx_en     (st_q.tx_en)
);

// File: tb/uart_dual_fifo_test.sv
module uart_dual_fifo_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        tx_valid, tx_take = 1'b0;
    logic [7:0]  tx_char;
    logic        rx_strobe = 1'b0, rx_start = 1'b0, char_tick = 1'b0;
    logic [7:0]  rx_char = 8'h0;
    logic        irq_tx, irq_rx;

    int checks = 0;
    int fails  = 0;
    logic [15:0] v;

    always #4 clk = ~clk;

    uart_dual_fifo uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
        .tx_char(tx_char), .tx_take(tx_take), .rx_strobe(rx_strobe), .rx_char(rx_char),
        .rx_start(rx_start), .char_tick(char_tick), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    function automatic logic [7:0] tx_pat(int k);
        return 8'((k * 37 + 5) & 255);
    endfunction
    function automatic logic [7:0] rx_pat(int k);
        return 8'((k * 101 + 17) & 255);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        @(negedge clk);
        bus_addr = a;
        bus_rd = (a == 2'd0);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rx_put(logic [7:0] c);
        @(negedge clk);
        rx_strobe = 1'b1; rx_char = c;
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    task automatic tick_char();
        @(negedge clk);
        char_tick = 1'b1;
        @(negedge clk);
        char_tick = 1'b0;
    endtask

    task automatic start_bit();
        @(negedge clk);
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
    endtask

    task automatic take_chk(logic [7:0] exp);
        @(negedge clk);
        chk("R2 tx_valid", tx_valid, 1);
        chk("R2 tx_char order", tx_char, exp);
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd2, v); chk("R1 count", v, 16'h0000);
        rd(2'd1, v); chk("R1 ctrl", v, 16'h0000);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 irq_tx", irq_tx, 0);
        chk("R1 irq_rx", irq_rx, 0);

        // R6 disabled FIFOs ignore pushes
        for (int k = 0; k < 3; k++) wr(2'd0, 16'h00A5);
        for (int k = 0; k < 3; k++) rx_put(8'h5A);
        rd(2'd2, v); chk("R6 disabled counts", v, 16'h0000);
        chk("R6 tx_valid off", tx_valid, 0);

        // R8 refill request after enabling
        wr(2'd1, 16'h0003);
        rd(2'd1, v); chk("R8 drq set when empty", v, 16'h0403);
        chk("R9 irq_tx gated", irq_tx, 0);

        // R2/R3 fill transmit FIFO plus one extra
        for (int k = 0; k < 128; k++) begin
            wr(2'd0, {8'h00, tx_pat(k)});
            if (k == 63) begin
                rd(2'd2, v); chk("R2 tx level mid", v, 16'h0040);
            end
        end
        wr(2'd0, 16'h00EE);
        rd(2'd2, v); chk("R3 tx full level", v, 16'h0080);
        rd(2'd1, v); chk("R8 drq held", v, 16'h0403);
        wr(2'd1, 16'h0603);
        rd(2'd1, v); chk("R8 drq kept by 1", v, 16'h0603);
        chk("R9 irq_tx on", irq_tx, 1);
        wr(2'd1, 16'h0203);
        rd(2'd1, v); chk("R8 drq cleared", v, 16'h0203);
        chk("R9 irq_tx off", irq_tx, 0);
        wr(2'd1, 16'h0603);
        rd(2'd1, v); chk("R8 write 1 no set", v, 16'h0203);

        for (int k = 0; k < 128; k++) take_chk(tx_pat(k));
        chk("R3 extra dropped", tx_valid, 0);
        rd(2'd1, v); chk("R8 drq after drain", v, 16'h0603);
        chk("R9 irq_tx drain", irq_tx, 1);

        // R4/R5/R10 receive path with trigger 16
        wr(2'd2, 16'h1000);
        for (int k = 0; k < 128; k++) begin
            rx_put(rx_pat(k));
            if (k >= 13 && k <= 17) chk("R10 trigger 16", irq_rx, (k + 1 >= 16) ? 1 : 0);
        end
        rd(2'd2, v); chk("R4 rx level", v, 16'h8000);
        rx_put(8'h33);
        rd(2'd2, v); chk("R5 level after overrun", v, 16'h8000);
        rd(2'd1, v); chk("R5 overrun flag", v, 16'h1603);
        for (int k = 0; k < 128; k++) begin
            rd(2'd0, v); chk("R4 rx order", v, {8'h00, rx_pat(k)});
            if (k == 63) begin
                rd(2'd2, v); chk("R4 rx level mid", v, 16'h4000);
            end
        end
        rd(2'd2, v); chk("R4 rx empty", v, 16'h0000);
        chk("R10 irq_rx empty", irq_rx, 0);
        wr(2'd1, 16'h0203);
        rd(2'd1, v); chk("R5 overrun cleared", v, 16'h0603);

        // R11 idle detection
        for (int k = 0; k < 3; k++) rx_put(8'h40 + 8'(k));
        for (int k = 0; k < 4; k++) tick_char();
        chk("R11 idle gated", irq_rx, 0);
        wr(2'd1, 16'h0E03);
        chk("R11 idle irq", irq_rx, 1);
        start_bit();
        chk("R11 start clears idle", irq_rx, 0);
        for (int k = 0; k < 3; k++) tick_char();
        chk("R11 three ticks", irq_rx, 0);
        tick_char();
        chk("R11 fourth tick", irq_rx, 1);

        // R7 flushes
        for (int k = 0; k < 5; k++) wr(2'd0, 16'h0011);
        rd(2'd2, v); chk("R7 before flush", v, 16'h0305);
        wr(2'd1, 16'h0E07);
        rd(2'd2, v); chk("R7 tx flush only", v, 16'h0300);
        rd(2'd1, v); chk("R7 flush bits read 0", v, 16'h0E03);
        wr(2'd1, 16'h0E0B);
        rd(2'd2, v); chk("R7 rx flush", v, 16'h0000);
        chk("R11 idle gone when empty", irq_rx, 0);

        // R10 trigger sweep
        wr(2'd1, 16'h0003);
        for (int t = 0; t <= 6; t++) begin
            wr(2'd2, 16'(t) << 8);
            for (int n = 1; n <= 7; n++) begin
                rx_put(8'(n));
                chk("R10 trigger sweep", irq_rx, (t != 0 && n >= t) ? 1 : 0);
            end
            wr(2'd1, 16'h000B);
        end

        summary();
        $finish;
    end
endmodule